// File: doc/BRIEF.md
# Logical Destination IPI Router

This block resolves one inter-processor interrupt command into a delivery mask over `N` local interrupt units. A command carries a destination field, a physical/logical mode bit, a delivery mode, a vector and a self-shorthand bit. The router compares the command with each unit's ID, logical ID, destination format and task priority. It returns a one-hot or multi-hot mask that names the units which must latch the vector.

A command is presented with a one-cycle valid strobe. On the next clock edge the router registers the mask, the echoed vector and delivery mode, and two error flags, and it pulses `done_o` for one cycle. Physical commands pick the unit whose ID equals the destination. Logical commands use flat or cluster matching, and lowest-priority delivery narrows the matching set to a single unit. Latching the vector in the targets and any bus timing belong to the units that consume the mask.

Top module: `ipi_router`

## Requirements
- R1: `done_o` is high in exactly the cycle after each cycle in which `cmd_valid_i` is high, and low otherwise. While `done_o` is low, `mask_o`, `phys_err_o` and `fmt_err_o` are all zero.
- R2: In physical mode (`cmd_logical_i`=0, `cmd_self_i`=0), the mask is one-hot on the unit whose ID equals `cmd_dest_i`. If several units carry that ID, the lowest-indexed one is chosen.
- R3: In physical mode, if no unit ID equals `cmd_dest_i`, `phys_err_o` is set and the mask is zero.
- R4: In logical mode, a unit whose format field is 4'hF (flat) matches when its logical ID ANDed with `cmd_dest_i` is nonzero.
- R5: In logical mode, a unit whose format field is 4'h0 (cluster) matches when the upper nibbles of its logical ID and `cmd_dest_i` are equal and the lower nibbles share at least one set bit.
- R6: In logical mode, if any unit has a format field other than 4'hF or 4'h0, `fmt_err_o` is set and the mask is zero.
- R7: In logical mode with any delivery mode other than 3'b001, the mask holds every matching unit.
- R8: In logical mode with delivery mode 3'b001 (lowest priority), the mask is one-hot on the matching unit with the smallest task priority, and ties go to the lowest index. If no unit matches, the mask is zero and no error is raised.
- R9: With `cmd_self_i`=1, the mask is one-hot on `src_unit_i` regardless of destination mode, destination field or formats, and neither error flag is set.
- R10: With `done_o`, `vector_o` and `dlv_mode_o` equal the vector and delivery mode of the command that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_dest_i | input | ID_W | Destination field |
| cmd_logical_i | input | 1 | 1 = logical destination, 0 = physical |
| cmd_dlv_mode_i | input | 3 | Delivery mode, 3'b001 = lowest priority |
| cmd_vector_i | input | VEC_W | Interrupt vector |
| cmd_self_i | input | 1 | Self shorthand |
| src_unit_i | input | IDX_W | Index of the sending unit |
| unit_id_i | input | N*ID_W | Per-unit IDs, unit i in slice i |
| unit_ldr_i | input | N*ID_W | Per-unit logical IDs |
| unit_fmt_i | input | N*4 | Per-unit destination format |
| unit_prio_i | input | N*PRIO_W | Per-unit task priority |
| done_o | output | 1 | Result valid pulse |
| mask_o | output | N | Delivery mask |
| vector_o | output | VEC_W | Echoed vector |
| dlv_mode_o | output | 3 | Echoed delivery mode |
| phys_err_o | output | 1 | Unmatched physical ID |
| fmt_err_o | output | 1 | Illegal format value |

## Verification
The hardest case to reach is a lowest-priority tie between matching units, combined with an equal or lower priority on a unit that does not match. Arbitration must then consider only the matching set and resolve the tie by index. The stimulus sets the priorities so that two matching units tie at the minimum while a non-matching unit holds an even smaller value. It also reconfigures the units into cluster format with mixed upper nibbles, so that lower-nibble overlap alone is not enough to match. The bench also gives two units the same ID to exercise physical selection by index.

// File: rtl/ipi_router_pkg.sv
package ipi_router_pkg;
  localparam logic [2:0] DLV_LOWEST = 3'b001;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
endpackage

// File: rtl/ipi_logic_match.sv
module ipi_logic_match #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] ldr_i,
  input  logic [3:0]      fmt_i,
  input  logic [ID_W-1:0] dest_i,
  output logic            hit_o,
  output logic            bad_fmt_o
);
  import ipi_router_pkg::*;
  localparam int HALF = ID_W / 2;

  always_comb begin
    hit_o     = 1'b0;
    bad_fmt_o = 1'b0;
    unique case (fmt_i)
      FMT_FLAT:    hit_o = |(ldr_i & dest_i);
      FMT_CLUSTER: hit_o = (ldr_i[ID_W-1:HALF] == dest_i[ID_W-1:HALF]) &&
                           |(ldr_i[HALF-1:0] & dest_i[HALF-1:0]);
      default:     bad_fmt_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ipi_min_pick.sv
module ipi_min_pick #(
  parameter int N      = 4,
  parameter int PRIO_W = 8
) (
  input  logic [N-1:0]        req_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic [N-1:0]        grant_o
);
  always_comb begin
    logic              found;
    logic [PRIO_W-1:0] best;
    found   = 1'b0;
    best    = '0;
    grant_o = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lower index on ties
      if (req_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        found   = 1'b1;
        best    = prio_i[i*PRIO_W +: PRIO_W];
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipi_router.sv
module ipi_router #(
  parameter int N      = 4,
  parameter int ID_W   = 8,
  parameter int PRIO_W = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [ID_W-1:0]     cmd_dest_i,
  input  logic                cmd_logical_i,
  input  logic [2:0]          cmd_dlv_mode_i,
  input  logic [VEC_W-1:0]    cmd_vector_i,
  input  logic                cmd_self_i,
  input  logic [IDX_W-1:0]    src_unit_i,
  input  logic [N*ID_W-1:0]   unit_id_i,
  input  logic [N*ID_W-1:0]   unit_ldr_i,
  input  logic [N*4-1:0]      unit_fmt_i,
  input  logic [N*PRIO_W-1:0] unit_prio_i,
  output logic                done_o,
  output logic [N-1:0]        mask_o,
  output logic [VEC_W-1:0]    vector_o,
  output logic [2:0]          dlv_mode_o,
  output logic                phys_err_o,
  output logic                fmt_err_o
);
  import ipi_router_pkg::*;

  logic [N-1:0] log_hit, bad_fmt, phys_hit, self_hot;
  logic [N-1:0] phys_grant, low_grant;

  for (genvar g = 0; g < N; g++) begin : g_unit
    ipi_logic_match #(.ID_W(ID_W)) match_i (
      .ldr_i     (unit_ldr_i[g*ID_W +: ID_W]),
      .fmt_i     (unit_fmt_i[g*4 +: 4]),
      .dest_i    (cmd_dest_i),
      .hit_o     (log_hit[g]),
      .bad_fmt_o (bad_fmt[g])
    );
    assign phys_hit[g] = (unit_id_i[g*ID_W +: ID_W] == cmd_dest_i);
    assign self_hot[g] = (src_unit_i == IDX_W'(g));
  end

  // equal priorities reduce the picker to a lowest-index selector
  ipi_min_pick #(.N(N), .PRIO_W(1)) phys_pick_i (
    .req_i   (phys_hit),
    .prio_i  ('0),
    .grant_o (phys_grant)
  );

  ipi_min_pick #(.N(N), .PRIO_W(PRIO_W)) low_pick_i (
    .req_i   (log_hit),
    .prio_i  (unit_prio_i),
    .grant_o (low_grant)
  );

  logic [N-1:0] mask_d;
  logic         perr_d, ferr_d;

  always_comb begin
    mask_d = '0;
    perr_d = 1'b0;
    ferr_d = 1'b0;
    if (cmd_self_i) begin
      mask_d = self_hot;
    end else if (!cmd_logical_i) begin
      mask_d = phys_grant;
      perr_d = ~|phys_hit;
    end else if (|bad_fmt) begin
      ferr_d = 1'b1;
    end else if (cmd_dlv_mode_i == DLV_LOWEST) begin
      mask_d = low_grant;
    end else begin
      mask_d = log_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      mask_o     <= '0;
      phys_err_o <= 1'b0;
      fmt_err_o  <= 1'b0;
      vector_o   <= '0;
      dlv_mode_o <= '0;
    end else begin
      done_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        mask_o     <= mask_d;
        phys_err_o <= perr_d;
        fmt_err_o  <= ferr_d;
        vector_o   <= cmd_vector_i;
        dlv_mode_o <= cmd_dlv_mode_i;
      end else begin
        mask_o     <= '0;
        phys_err_o <= 1'b0;
        fmt_err_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_router_chk.sv
module ipi_router_chk #(
  parameter int N      = 4,
  parameter int ID_W   = 8,
  parameter int PRIO_W = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic                cmd_logical_i,
  input logic [2:0]          cmd_dlv_mode_i,
  input logic [VEC_W-1:0]    cmd_vector_i,
  input logic                cmd_self_i,
  input logic [IDX_W-1:0]    src_unit_i,
  input logic                done_o,
  input logic [N-1:0]        mask_o,
  input logic [VEC_W-1:0]    vector_o,
  input logic                phys_err_o,
  input logic                fmt_err_o
);
  logic [N-1:0] src_hot;
  assign src_hot = N'(1) << src_unit_i;

  assert_done_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  assert_done_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);
  assert_idle_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (mask_o == '0 && !phys_err_o && !fmt_err_o));
  assert_phys_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_self_i && !cmd_logical_i) |=>
      (phys_err_o ? (mask_o == '0) : ($countones(mask_o) == 1)));
  assert_err_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (phys_err_o || fmt_err_o)) |-> (mask_o == '0));
  assert_lowest_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_self_i && cmd_logical_i && cmd_dlv_mode_i == 3'b001) |=>
      ($countones(mask_o) <= 1));
  assert_self_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_self_i) |=>
      (mask_o == $past(src_hot) && !phys_err_o && !fmt_err_o));
  assert_vector_echo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (vector_o == $past(cmd_vector_i)));
endmodule

bind ipi_router ipi_router_chk #(.N(N), .ID_W(ID_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_logical_i  (cmd_logical_i),
  .cmd_dlv_mode_i (cmd_dlv_mode_i),
  .cmd_vector_i   (cmd_vector_i),
  .cmd_self_i     (cmd_self_i),
  .src_unit_i     (src_unit_i),
  .done_o         (done_o),
  .mask_o         (mask_o),
  .vector_o       (vector_o),
  .phys_err_o     (phys_err_o),
  .fmt_err_o      (fmt_err_o)
);

// File: tb/ipi_router_tb_top.sv
module ipi_router_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;

  logic          cmd_valid = 0, cmd_logical = 0, cmd_self = 0;
  logic [W-1:0]  cmd_dest = 0, cmd_vector = 0;
  logic [2:0]    cmd_mode = 0;
  logic [1:0]    src_unit = 0;
  logic [N*W-1:0] ids, ldrs, prios;
  logic [N*4-1:0] fmts;
  logic          done;
  logic [N-1:0]  mask;
  logic [W-1:0]  vec_out;
  logic [2:0]    mode_out;
  logic          perr, ferr;

  ipi_router #(.N(N), .ID_W(W), .PRIO_W(W), .VEC_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_dest_i(cmd_dest),
    .cmd_logical_i(cmd_logical), .cmd_dlv_mode_i(cmd_mode), .cmd_vector_i(cmd_vector),
    .cmd_self_i(cmd_self), .src_unit_i(src_unit), .unit_id_i(ids), .unit_ldr_i(ldrs),
    .unit_fmt_i(fmts), .unit_prio_i(prios), .done_o(done), .mask_o(mask),
    .vector_o(vec_out), .dlv_mode_o(mode_out), .phys_err_o(perr), .fmt_err_o(ferr));

  typedef struct {
    logic [N-1:0] mask;
    logic         perr, ferr;
    logic [W-1:0] vec;
    logic [2:0]   mode;
    string        tag;
  } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic lg, input logic [W-1:0] dst,
                      input logic [2:0] md, input logic sf, input logic [1:0] src,
                      input logic [W-1:0] vec, input logic [N-1:0] em,
                      input logic ep, input logic ef);
    exp_t e;
    e.mask = em; e.perr = ep; e.ferr = ef; e.vec = vec; e.mode = md; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1; cmd_logical = lg; cmd_dest = dst; cmd_mode = md;
    cmd_self = sf; src_unit = src; cmd_vector = vec;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (done) begin
          if (sb.size() == 0) chk("R1 unexpected done", 1, 0);
          else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " mask"}, 32'(mask), 32'(e.mask));
            chk({e.tag, " phys_err"}, 32'(perr), 32'(e.perr));
            chk({e.tag, " fmt_err"}, 32'(ferr), 32'(e.ferr));
            chk({e.tag, " R10 vector"}, 32'(vec_out), 32'(e.vec));
            chk({e.tag, " R10 mode"}, 32'(mode_out), 32'(e.mode));
          end
        end else begin
          if (mask !== '0 || perr !== 0 || ferr !== 0) chk("R1 idle outputs", 1, 0);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // unit 3..0 in descending slice order
    ids   = {8'h13, 8'h11, 8'h11, 8'h10};
    ldrs  = {8'h08, 8'h04, 8'h02, 8'h01};
    fmts  = {4'hF, 4'hF, 4'hF, 4'hF};
    prios = {8'h10, 8'h20, 8'h10, 8'h30};
    repeat (3) @(negedge clk);
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset mask", 32'(mask), 0);
    rst_ni = 1;
    @(negedge clk);

    send("R2 phys unit0",       0, 8'h10, 3'b000, 0, 0, 8'h21, 4'b0001, 0, 0);
    send("R2 phys unit3",       0, 8'h13, 3'b100, 0, 0, 8'h22, 4'b1000, 0, 0);
    send("R2 phys dup id",      0, 8'h11, 3'b000, 0, 0, 8'h23, 4'b0010, 0, 0);
    send("R3 phys no match",    0, 8'h55, 3'b000, 0, 0, 8'h24, 4'b0000, 1, 0);
    send("R4 R7 flat multi",    1, 8'h0B, 3'b000, 0, 0, 8'h25, 4'b1011, 0, 0);
    send("R4 flat none",        1, 8'hF0, 3'b000, 0, 0, 8'h26, 4'b0000, 0, 0);
    send("R8 lowest tie",       1, 8'h0F, 3'b001, 0, 0, 8'h27, 4'b0010, 0, 0);
    send("R8 lowest subset",    1, 8'h0D, 3'b001, 0, 0, 8'h28, 4'b1000, 0, 0);
    send("R8 lowest single",    1, 8'h05, 3'b001, 0, 0, 8'h29, 4'b0100, 0, 0);
    send("R8 lowest none",      1, 8'h30, 3'b001, 0, 0, 8'h2A, 4'b0000, 0, 0);
    send("R9 self phys",        0, 8'h55, 3'b000, 1, 2, 8'h2B, 4'b0100, 0, 0);
    // back-to-back strobes
    @(negedge clk);
    sb.push_back('{4'b0001, 0, 0, 8'h2C, 3'b000, "R1 b2b first"});
    sb.push_back('{4'b1000, 0, 0, 8'h2D, 3'b000, "R1 b2b second"});
    cmd_valid = 1; cmd_logical = 0; cmd_self = 0; cmd_dest = 8'h10; cmd_vector = 8'h2C; cmd_mode = 0;
    @(negedge clk);
    cmd_dest = 8'h13; cmd_vector = 8'h2D;
    @(negedge clk);
    cmd_valid = 0;
    repeat (2) @(negedge clk);

    // cluster config: upper nibble = cluster, lower = member bits
    ldrs  = {8'h13, 8'h21, 8'h12, 8'h11};
    fmts  = {4'h0, 4'h0, 4'h0, 4'h0};
    prios = {8'h05, 8'h01, 8'h05, 8'h09};
    send("R5 R7 cluster one",   1, 8'h11, 3'b000, 0, 0, 8'h31, 4'b1001, 0, 0);
    send("R5 cluster other",    1, 8'h21, 3'b000, 0, 0, 8'h32, 4'b0100, 0, 0);
    send("R5 cluster no nib",   1, 8'h14, 3'b000, 0, 0, 8'h33, 4'b0000, 0, 0);
    send("R5 R8 cluster low",   1, 8'h13, 3'b001, 0, 0, 8'h34, 4'b0010, 0, 0);
    send("R9 self logical",     1, 8'h13, 3'b001, 1, 3, 8'h35, 4'b1000, 0, 0);

    // mixed formats: flat, cluster, and one illegal
    fmts = {4'h0, 4'h5, 4'hF, 4'h0};
    send("R6 illegal fmt",      1, 8'h11, 3'b000, 0, 0, 8'h41, 4'b0000, 0, 1);
    send("R6 illegal lowest",   1, 8'h11, 3'b001, 0, 0, 8'h42, 4'b0000, 0, 1);
    send("R6 phys ignores fmt", 0, 8'h11, 3'b000, 0, 0, 8'h43, 4'b0010, 0, 0);
    send("R9 self ignores fmt", 1, 8'h11, 3'b000, 1, 1, 8'h44, 4'b0010, 0, 0);

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", 32'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule